// File: doc/BRIEF.md
# Integer ALU with Status Flags and Barrel Shifter

This block is the purely combinational arithmetic and logic unit of a small 32-bit integer core. It takes two operands, a 3-bit operation code and a separate shift amount. It returns a result word and four status flags: zero, negative, carry and overflow. The core's next-PC logic uses these flags to decide conditional branches.

One shared adder does both addition and subtraction. To subtract, the adder inverts the second operand and sets its carry-in, so it computes A + ~B + 1. A branch on equality therefore runs a subtract and tests the zero flag; there is no separate comparator. The three shifts run in a dedicated barrel shifter. The datapath chooses the shift amount from the low bits of the second operand or from an immediate, and passes it on its own port. The block holds no state, so its outputs change in the same cycle as its inputs.

The block has no states and no transitions. It is a single combinational path: operand conditioning, then the adder and the shifter in parallel, then a result multiplexer, then flag generation.

Top module: `alu_core`

## Requirements
- R1: With op_sel = 0 (add), result equals (opnd_a + opnd_b) modulo 2^32.
- R2: With op_sel = 1 (subtract), result equals (opnd_a - opnd_b) modulo 2^32. The same adder computes it as opnd_a + ~opnd_b + 1.
- R3: With op_sel = 2, result is the bitwise AND of the operands. With op_sel = 3, result is their bitwise OR.
- R4: With op_sel = 4 (shift left), result is opnd_a shifted left by shamt, a 5-bit amount from 0 to 31. Vacated low bits are filled with 0.
- R5: With op_sel = 5 (logical shift right), result is opnd_a shifted right by shamt. Vacated high bits are filled with 0.
- R6: With op_sel = 6 (arithmetic shift right), result is opnd_a shifted right by shamt. Vacated high bits are filled with copies of opnd_a bit 31.
- R7: flag_z is 1 exactly when all 32 result bits are 0, and flag_n equals result bit 31, for every op_sel. After a subtract, flag_z is 1 exactly when the two operands are equal.
- R8: For add, flag_c is the carry out of bit 31. For subtract, flag_c is 1 exactly when opnd_a >= opnd_b as unsigned values (no borrow).
- R9: For add and subtract, flag_v is 1 exactly when the signed two's-complement result cannot be represented in 32 bits.
- R10: For op_sel values 2 to 7, flag_c and flag_v are both 0.
- R11: op_sel = 7 is unassigned. It yields result 0, so flag_z = 1.
- R12: The outputs depend only on the present inputs. A change at the inputs appears at the outputs without waiting for any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand |
| op_sel | input | 3 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 sll, 5 srl, 6 sra, 7 unassigned) |
| shamt | input | 5 | Shift amount |
| result | output | 32 | Operation result |
| flag_z | output | 1 | Result is all zeros |
| flag_n | output | 1 | Result bit 31 |
| flag_c | output | 1 | Adder carry out (no-borrow for subtract) |
| flag_v | output | 1 | Signed overflow of add or subtract |

## Verification
Random operands show that the adder, the logic and the shifter agree with a bench model across the whole space. Directed pairs target the points where a flag changes. Equal operands and operands that differ by one under subtract separate a correct zero test from a faulty one. Unsigned wrap values such as 0xFFFFFFFF + 1 and 0 - 1 expose carry polarity errors. Sign-boundary sums such as 0x7FFFFFFF + 1 and 0x80000000 - 1 expose overflow errors. Negative and positive words shifted by 0, 1 and 31 show whether the right-shift fill follows bit 31 or stays at zero, and whether the 0 and 31 edges of the shift amount work.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_SLL = 3'd4,
        OP_SRL = 3'd5,
        OP_SRA = 3'd6,
        OP_NUL = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } alu_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_cond;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_cond = b ^ {WIDTH{sub}};
        wide   = {1'b0, a} + {1'b0, b_cond} + {{WIDTH{1'b0}}, sub};
        sum    = wide[WIDTH-1:0];
        cout   = wide[WIDTH];
        ovf    = (a[MSB] == b_cond[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_barrel.sv
module alu_barrel #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SHW-1:0]   amt,
    input  logic             to_left,
    input  logic             arith,
    output logic [WIDTH-1:0] dout
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] stage [0:SHW];
    logic             fill;
    logic [WIDTH-1:0] flipped_in;

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            flipped_in[i] = din[MSB-i];
        end
        fill     = arith & ~to_left & din[MSB];
        stage[0] = to_left ? flipped_in : din;
    end

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int DIST = 1 << s;
        always_comb begin
            if (amt[s]) begin
                stage[s+1] = {{DIST{fill}}, stage[s][WIDTH-1:DIST]};
            end else begin
                stage[s+1] = stage[s];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            dout[i] = to_left ? stage[SHW][MSB-i] : stage[SHW][i];
        end
    end
endmodule

// File: rtl/alu_flaggen.sv
module alu_flaggen #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]          res,
    input  logic                      arith_op,
    input  logic                      cout,
    input  logic                      ovf,
    output alu_pkg::alu_flags_t       flags
);
    always_comb begin
        flags.z = ~|res;
        flags.n = res[WIDTH-1];
        flags.c = arith_op & cout;
        flags.v = arith_op & ovf;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [2:0]       op_sel,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] result,
    output logic             flag_z,
    output logic             flag_n,
    output logic             flag_c,
    output logic             flag_v
);
    import alu_pkg::*;

    alu_op_e          op;
    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] shifted;
    logic             cout;
    logic             ovf;
    logic             is_sub;
    logic             is_arith;
    alu_flags_t       flags;

    always_comb begin
        op       = alu_op_e'(op_sel);
        is_sub   = (op == OP_SUB);
        is_arith = (op == OP_ADD) || (op == OP_SUB);
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a    (opnd_a),
        .b    (opnd_b),
        .sub  (is_sub),
        .sum  (sum),
        .cout (cout),
        .ovf  (ovf)
    );

    alu_barrel #(.WIDTH(WIDTH), .SHW(SHW)) u_barrel (
        .din     (opnd_a),
        .amt     (shamt),
        .to_left (op == OP_SLL),
        .arith   (op == OP_SRA),
        .dout    (shifted)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:         result = sum;
            OP_AND:                 result = opnd_a & opnd_b;
            OP_OR:                  result = opnd_a | opnd_b;
            OP_SLL, OP_SRL, OP_SRA: result = shifted;
            default:                result = '0;
        endcase
    end

    alu_flaggen #(.WIDTH(WIDTH)) u_flags (
        .res      (result),
        .arith_op (is_arith),
        .cout     (cout),
        .ovf      (ovf),
        .flags    (flags)
    );

    always_comb begin
        flag_z = flags.z;
        flag_n = flags.n;
        flag_c = flags.c;
        flag_v = flags.v;
    end
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic [2:0]       op_sel,
    input logic [SHW-1:0]   shamt,
    input logic [WIDTH-1:0] result,
    input logic             flag_z,
    input logic             flag_n,
    input logic             flag_c,
    input logic             flag_v
);
    always_comb begin
        if (!$isunknown({opnd_a, opnd_b, op_sel, shamt})) begin
            // R7
            sub_eq_zero_chk: assert (op_sel != 3'd1 || flag_z == (opnd_a == opnd_b));
            // R8
            sub_carry_chk: assert (op_sel != 3'd1 || flag_c == (opnd_a >= opnd_b));
            // R10
            logic_no_cv_chk: assert (op_sel < 3'd2 || (!flag_c && !flag_v));
            // R6
            sra_sign_fill_chk: assert (op_sel != 3'd6 || result[WIDTH-1] == opnd_a[WIDTH-1]);
            // R5
            srl_zero_fill_chk: assert (op_sel != 3'd5 || shamt == '0 || !result[WIDTH-1]);
            // R11
            unassigned_zero_chk: assert (op_sel != 3'd7 || (result == '0 && flag_z));
            // R7
            neg_flag_chk: assert (flag_n == result[WIDTH-1]);
        end
    end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH), .SHW(SHW)) u_alu_core_chk (
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .op_sel (op_sel),
    .shamt  (shamt),
    .result (result),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .flag_c (flag_c),
    .flag_v (flag_v)
);

// File: tb/tb_alu_core.sv
module tb_alu_core;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic [31:0] opnd_a, opnd_b, result;
    logic [2:0]  op_sel;
    logic [4:0]  shamt;
    logic        flag_z, flag_n, flag_c, flag_v;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_core dut (
        .opnd_a (opnd_a), .opnd_b (opnd_b), .op_sel (op_sel), .shamt (shamt),
        .result (result), .flag_z (flag_z), .flag_n (flag_n),
        .flag_c (flag_c), .flag_v (flag_v)
    );

    function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [2:0] op, input logic [4:0] sh);
        logic [32:0] w;
        logic [31:0] r;
        logic c, v;
        c = 1'b0; v = 1'b0; r = '0;
        case (op)
            3'd0: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[31:0]; c = w[32];
                v = (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'd1: begin
                r = a - b; c = (a >= b);
                v = (a[31] != b[31]) && (r[31] != a[31]);
            end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a << sh;
            3'd5: r = a >> sh;
            3'd6: r = 32'($signed(a) >>> sh);
            default: r = '0;
        endcase
        return {r, (r == 32'd0), r[31], c, v};
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2, 3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            3'd6: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic cmp(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] op, input logic [4:0] sh);
        logic [35:0] e;
        @(negedge clk);
        opnd_a = a; opnd_b = b; op_sel = op; shamt = sh;
        #1; // R12: outputs settle with no clock edge in between
        e = model(a, b, op, sh);
        cmp(tag_of(op), "result", result, e[35:4]);
        cmp("R7", "flag_z", {31'd0, flag_z}, {31'd0, e[3]});
        cmp("R7", "flag_n", {31'd0, flag_n}, {31'd0, e[2]});
        cmp(op < 3'd2 ? "R8" : "R10", "flag_c", {31'd0, flag_c}, {31'd0, e[1]});
        cmp(op < 3'd2 ? "R9" : "R10", "flag_v", {31'd0, flag_v}, {31'd0, e[0]});
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240607;
        void'($urandom(seed));
        opnd_a = '0; opnd_b = '0; op_sel = 3'd0; shamt = '0;
        // R12: change inputs mid-cycle and observe at once
        #2;
        opnd_a = 32'd5; opnd_b = 32'd7;
        #1 cmp("R12", "comb result", result, 32'd12);
        // Directed corners
        apply(32'hFFFF_FFFF, 32'd1, 3'd0, 5'd0);          // R8 carry, zero
        apply(32'h7FFF_FFFF, 32'd1, 3'd0, 5'd0);          // R9 overflow
        apply(32'h8000_0000, 32'h8000_0000, 3'd0, 5'd0);  // R9 neg overflow
        apply(32'd0, 32'd1, 3'd1, 5'd0);                  // R8 borrow
        apply(32'h1234_5678, 32'h1234_5678, 3'd1, 5'd0);  // R7 equal
        apply(32'h1234_5678, 32'h1234_5677, 3'd1, 5'd0);  // R7 differ by one
        apply(32'h8000_0000, 32'd1, 3'd1, 5'd0);          // R9 sub overflow
        apply(32'hF0F0_F0F0, 32'hFF00_FF00, 3'd2, 5'd0);  // R3
        apply(32'hF0F0_F0F0, 32'h0F0F_0000, 3'd3, 5'd0);  // R3
        for (int s = 0; s < 32; s += 31) begin
            apply(32'h8000_0001, 32'd0, 3'd4, 5'(s));     // R4
            apply(32'h8000_0001, 32'd0, 3'd5, 5'(s));     // R5
            apply(32'h8000_0001, 32'd0, 3'd6, 5'(s));     // R6
            apply(32'h4000_0000, 32'd0, 3'd6, 5'(s));     // R6 positive
        end
        apply(32'hA5A5_A5A5, 32'hFFFF_FFFF, 3'd6, 5'd1);  // R6
        apply(32'hDEAD_BEEF, 32'h1, 3'd7, 5'd3);          // R11
        // Constrained random
        for (int k = 0; k < 600; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = (k % 5 == 0) ? ra : $urandom;
            apply(ra, rb, 3'($urandom_range(0, 7)), 5'($urandom));
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule